// File: doc/BRIEF.md
# Zero-Turnaround Pipelined SRAM

This block is a synthesizable clocked model of a synchronous pipelined SRAM. Its word is two 9-bit byte lanes and its depth is set by a parameter. Reads, writes and deselects can follow one another on every clock with no idle cycles in between. Read data appears one clock after the command edge. Write data is taken one clock later than that, which is two edges after the command. Because of this offset, the shared data bus of a real system never needs a turnaround gap.

A command edge either loads a new address or continues a burst. When it continues a burst, a 2-bit counter on the two lowest address bits steps through four beats. The counter steps in linear or interleaved order, and a strap input picks the order. A clock-enable input freezes the whole pipeline. Per-lane byte selects mask writes. A read that catches a write still in flight to the same address returns the new data. Data-in and data-out are separate buses. A data-valid flag stands in for the three-state control of the pins, and an asynchronous output-enable input gates that flag.

Top module: `zt_sram`

## Requirements
- R1: An edge starts a new access only when cen_n=0, adv_ld=0, ce1_n=0, ce2=1 and ce3_n=0. we_n=1 makes it a read and we_n=0 makes it a write. With adv_ld=0 and any chip enable inactive, the edge is a deselect and nothing is written.
- R2: For a read captured on edge E, dout carries the addressed word and dout_en is 1 after edge E+1. The data holds until edge E+2, where the host samples it.
- R3: For a write captured on edge E, din and bws_n are taken on edge E+2. dout_en is 0 between edges E+1 and E+2, whatever oe_n is.
- R4: bws_n[0]=0 enables writing din[8:0] and bws_n[1]=0 enables writing din[17:9]. A lane whose select is 1 keeps its stored contents.
- R5: With cen_n=1 the edge has no effect. dout and dout_en hold, nothing is written, and no command, data or byte select is taken.
- R6: With adv_ld=1 after an accepted access, the edge issues the next beat of the same kind (read or write). Address and chip enables are ignored on such an edge, and so is we_n. The beat counter on address bits [1:0] wraps, so the fifth beat reuses the start address.
- R7: With mode_il=0, beat n uses low bits (start+n) mod 4. With mode_il=1, it uses start XOR n. Address bits above bit 1 stay those of the start address.
- R8: A deselect on edge E brings dout_en to 0 after edge E+1. adv_ld=1 while deselected keeps the block deselected. After reset dout_en is 0, and it stays 0 for the first cycle after leaving the deselected state.
- R9: A read issued on the edge right after a write to the same address returns the newly written lanes merged with the old contents of the unwritten lanes.
- R10: dout_en is 1 only when the pipeline drives read data and oe_n=0. It follows oe_n without waiting for a clock.
- R11: Reads and writes can be issued on consecutive edges in any mix, and every one completes with the timing of R2 and R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cen_n | input | 1 | Clock enable, active low; high freezes all state |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adv_ld | input | 1 | 0 loads a new address, 1 advances the burst |
| we_n | input | 1 | 0 write, 1 read, sampled on load edges |
| addr | input | ADDR_W | Word address |
| bws_n | input | LANES | Byte write selects, active low, sampled on the data edge |
| mode_il | input | 1 | Burst order strap: 0 linear, 1 interleaved |
| din | input | LANES*LANE_W | Write data, taken two edges after the command |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dout | output | LANES*LANE_W | Read data |
| dout_en | output | 1 | High while dout is driven onto the data pins |

## Verification
On every cycle the assertions check the following: rejection of commands without full chip select, the drive decision that follows a read, write or deselect, the freeze under a high clock enable, the kind carried through a burst beat, and gating by oe_n. Only the directed scenarios can show the data itself. That covers the stored and merged lane contents, the linear and interleaved beat addresses with wrap, the bypass of an in-flight write, and the fact that garbage on inputs during a freeze or on a rejected write leaves memory untouched.

// File: rtl/zt_sram_pkg.sv
`timescale 1ns/1ps
package zt_sram_pkg;
  localparam int LANE_W_DEF = 9;
  localparam int LANES_DEF  = 2;

  // low address bits of a burst beat; il selects xor order, else modulo-4 count
  function automatic logic [1:0] beat_low(input logic il, input logic [1:0] start,
                                          input logic [1:0] beat);
    logic [1:0] r;
    if (il) r = start ^ beat;
    else    r = start + beat;
    return r;
  endfunction
endpackage

// File: rtl/zt_burst_ctl.sv
`timescale 1ns/1ps
module zt_burst_ctl
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              adv_ld,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              mode_il,
  output logic              iss_valid,
  output logic              iss_write,
  output logic [ADDR_W-1:0] iss_addr,
  output logic              burst_on,
  output logic              burst_wr
);
  logic              sel;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        beat_q;
  logic [1:0]        beat_nx;

  assign sel     = !ce1_n && ce2 && !ce3_n;
  assign beat_nx = beat_q + 2'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      burst_on  <= 1'b0;
      burst_wr  <= 1'b0;
      base_q    <= '0;
      beat_q    <= '0;
      iss_valid <= 1'b0;
      iss_write <= 1'b0;
      iss_addr  <= '0;
    end else if (step) begin
      if (!adv_ld) begin
        // load edge: a new access or a deselect
        burst_on  <= sel;
        burst_wr  <= !we_n;
        base_q    <= addr;
        beat_q    <= 2'd0;
        iss_valid <= sel;
        iss_write <= !we_n;
        iss_addr  <= addr;
      end else begin
        // advance edge: chip enables and we_n are not looked at
        beat_q    <= beat_nx;
        iss_valid <= burst_on;
        iss_write <= burst_wr;
        iss_addr  <= {base_q[ADDR_W-1:2], beat_low(mode_il, base_q[1:0], beat_nx)};
      end
    end
  end
endmodule

// File: rtl/zt_sram_lane.sv
`timescale 1ns/1ps
module zt_sram_lane #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9
) (
  input  logic              clk,
  input  logic              step,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];

  // simple dual-port, read-first, shared clock enable
  always_ff @(posedge clk) begin
    if (step) begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
    end
  end
endmodule

// File: rtl/zt_out_stage.sv
`timescale 1ns/1ps
module zt_out_stage #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  localparam int WORD_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              wr_pend,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LANES-1:0]  bws_n,
  input  logic [WORD_W-1:0] din,
  input  logic [WORD_W-1:0] ram_q,
  input  logic              oe_n,
  output logic [WORD_W-1:0] dout,
  output logic              dout_en,
  output logic              drv
);
  logic              hit;
  logic [LANES-1:0]  byp_mask;
  logic [WORD_W-1:0] byp_q;

  assign hit = rd_req && wr_pend && (wr_addr == rd_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      drv      <= 1'b0;
      byp_mask <= '0;
      byp_q    <= '0;
    end else if (step) begin
      drv      <= rd_req;
      byp_mask <= {LANES{hit}} & ~bws_n;
      byp_q    <= din;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_mux
    assign dout[l*LANE_W +: LANE_W] = byp_mask[l] ? byp_q[l*LANE_W +: LANE_W]
                                                  : ram_q[l*LANE_W +: LANE_W];
  end

  assign dout_en = drv && !oe_n;
endmodule

// File: rtl/zt_sram.sv
`timescale 1ns/1ps
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANE_W = LANE_W_DEF,
  parameter int LANES  = LANES_DEF,
  localparam int WORD_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cen_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              adv_ld,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  bws_n,
  input  logic              mode_il,
  input  logic [WORD_W-1:0] din,
  input  logic              oe_n,
  output logic [WORD_W-1:0] dout,
  output logic              dout_en
);
  logic              step;
  logic              iss_valid, iss_write;
  logic [ADDR_W-1:0] iss_addr;
  logic              burst_on, burst_wr;
  logic              wr2_valid;
  logic [ADDR_W-1:0] wr2_addr;
  logic [WORD_W-1:0] ram_q;
  logic              drv;

  assign step = !cen_n;

  zt_burst_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rst(rst), .step(step),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .adv_ld(adv_ld), .we_n(we_n), .addr(addr), .mode_il(mode_il),
    .iss_valid(iss_valid), .iss_write(iss_write), .iss_addr(iss_addr),
    .burst_on(burst_on), .burst_wr(burst_wr)
  );

  // second stage: a write waits here for its data edge
  always_ff @(posedge clk) begin
    if (rst) begin
      wr2_valid <= 1'b0;
      wr2_addr  <= '0;
    end else if (step) begin
      wr2_valid <= iss_valid && iss_write;
      wr2_addr  <= iss_addr;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    zt_sram_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
      .clk(clk), .step(step),
      .we(wr2_valid && !bws_n[l]),
      .waddr(wr2_addr),
      .wdata(din[l*LANE_W +: LANE_W]),
      .raddr(iss_addr),
      .rdata(ram_q[l*LANE_W +: LANE_W])
    );
  end

  zt_out_stage #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_out (
    .clk(clk), .rst(rst), .step(step),
    .rd_req(iss_valid && !iss_write), .rd_addr(iss_addr),
    .wr_pend(wr2_valid), .wr_addr(wr2_addr),
    .bws_n(bws_n), .din(din), .ram_q(ram_q), .oe_n(oe_n),
    .dout(dout), .dout_en(dout_en), .drv(drv)
  );
endmodule

// File: rtl/zt_sram_chk.sv
`timescale 1ns/1ps
module zt_sram_chk #(
  parameter int WORD_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              cen_n,
  input logic              ce1_n,
  input logic              ce2,
  input logic              ce3_n,
  input logic              adv_ld,
  input logic              oe_n,
  input logic [WORD_W-1:0] dout,
  input logic              dout_en,
  input logic              iss_valid,
  input logic              iss_write,
  input logic              burst_on,
  input logic              burst_wr,
  input logic              drv
);
  p_accept_r1: assert property (@(posedge clk) disable iff (rst)
    (!cen_n && !adv_ld && (ce1_n || !ce2 || ce3_n)) |=> !iss_valid);

  p_read_drive_r2: assert property (@(posedge clk) disable iff (rst)
    (!cen_n && iss_valid && !iss_write) |=> drv);

  p_write_hiz_r3: assert property (@(posedge clk) disable iff (rst)
    (!cen_n && iss_valid && iss_write) |=> !dout_en);

  p_freeze_r5: assert property (@(posedge clk) disable iff (rst)
    cen_n |=> ($stable(dout) && $stable(drv) && $stable(iss_valid)));

  p_burst_kind_r6: assert property (@(posedge clk) disable iff (rst)
    (!cen_n && adv_ld && burst_on) |=> (iss_valid && (iss_write == $past(burst_wr))));

  p_deselect_r8: assert property (@(posedge clk) disable iff (rst)
    (!cen_n && !iss_valid) |=> !drv);

  p_reset_off_r8: assert property (@(posedge clk)
    $past(rst) |-> !drv);

  p_oe_gate_r10: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> !dout_en);
endmodule

bind zt_sram zt_sram_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .cen_n(cen_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
  .adv_ld(adv_ld), .oe_n(oe_n), .dout(dout), .dout_en(dout_en),
  .iss_valid(iss_valid), .iss_write(iss_write),
  .burst_on(burst_on), .burst_wr(burst_wr), .drv(drv)
);

// File: tb/test_zt_sram.sv
`timescale 1ns/1ps
module test_zt_sram;
  localparam int K_DS = 0, K_RD = 1, K_WR = 2, K_ADV = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cen_n = 1'b0, ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1;
  logic        adv_ld = 1'b0, we_n = 1'b1, mode_il = 1'b0, oe_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [1:0]  bws_n = 2'b11;
  logic [17:0] din = '0;
  logic [17:0] dout;
  logic        dout_en;

  zt_sram i_zt_sram (
    .clk(clk), .rst(rst), .cen_n(cen_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .adv_ld(adv_ld), .we_n(we_n), .addr(addr), .bws_n(bws_n), .mode_il(mode_il),
    .din(din), .oe_n(oe_n), .dout(dout), .dout_en(dout_en)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [17:0] mdl [256];

  // bench-side view of commands in flight
  int k1 = K_DS, k2 = K_DS;
  logic [17:0] d1 = '0, d2 = '0;
  logic [1:0]  w1 = 2'b11, w2 = 2'b11;
  string t1 = "R8", t2 = "R8";
  bit          b_on = 1'b0, b_wr = 1'b0;
  logic [7:0]  b_base = '0;
  logic [1:0]  b_beat = '0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [17:0] act, input logic [17:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // one recognized edge: check the command from two edges back, feed its data,
  // drive the new command, then advance to the next falling edge
  task automatic cycle(input int kind, input logic [7:0] a, input logic [17:0] wd,
                       input logic [1:0] bw, input string rq);
    int k;
    logic [7:0]  ea;
    logic [17:0] ed;
    if (k2 == K_RD) begin
      chk(dout_en === 1'b1, t2, "read drive", {17'd0, dout_en}, 18'd1);
      chk(dout === d2, t2, "read data", dout, d2);
    end else begin
      chk(dout_en === 1'b0, t2, "pins off", {17'd0, dout_en}, 18'd0);
    end
    din   = (k2 == K_WR) ? d2 : 18'($urandom);
    bws_n = (k2 == K_WR) ? w2 : 2'($urandom);
    cen_n = 1'b0;
    k  = kind;
    ea = a;
    ed = wd;
    if (kind == K_ADV) begin
      adv_ld = 1'b1;
      addr   = 8'($urandom);
      ce1_n  = 1'b1; ce2 = 1'b0; ce3_n = 1'b1;
      we_n   = b_wr;  // opposite of the burst kind: must be ignored
      if (b_on) begin
        b_beat = b_beat + 2'd1;
        ea = {b_base[7:2], mode_il ? (b_base[1:0] ^ b_beat) : (b_base[1:0] + b_beat)};
        k  = b_wr ? K_WR : K_RD;
      end else begin
        k = K_DS;
      end
    end else begin
      adv_ld = 1'b0;
      addr   = a;
      if (kind == K_DS) begin
        we_n = 1'b0;
        case (a[1:0])
          2'd0: begin ce1_n = 1'b1; ce2 = 1'b1; ce3_n = 1'b0; end
          2'd1: begin ce1_n = 1'b0; ce2 = 1'b0; ce3_n = 1'b0; end
          2'd2: begin ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b1; end
          default: begin ce1_n = 1'b1; ce2 = 1'b0; ce3_n = 1'b1; end
        endcase
        b_on = 1'b0;
      end else begin
        ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
        we_n  = (kind == K_RD);
        b_on = 1'b1; b_wr = (kind == K_WR); b_base = a; b_beat = 2'd0;
      end
    end
    if (k == K_WR) begin
      if (!bw[0]) mdl[ea][8:0]  = wd[8:0];
      if (!bw[1]) mdl[ea][17:9] = wd[17:9];
    end
    if (k == K_RD) ed = mdl[ea];
    k2 = k1; d2 = d1; w2 = w1; t2 = t1;
    k1 = k;  d1 = (k == K_WR) ? wd : ed; w1 = bw; t1 = rq;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic flush(input string rq);
    cycle(K_DS, 8'h03, '0, 2'b11, rq);
    cycle(K_DS, 8'h00, '0, 2'b11, rq);
  endtask

  task automatic freeze(input int n);
    logic [17:0] sd;
    logic        se;
    sd = dout; se = dout_en;
    cen_n = 1'b1;
    adv_ld = 1'($urandom); ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
    we_n = 1'b0; addr = 8'($urandom); din = 18'($urandom); bws_n = 2'b00;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      chk(dout === sd, "R5", "frozen dout", dout, sd);
      chk(dout_en === se, "R5", "frozen dout_en", {17'd0, dout_en}, {17'd0, se});
    end
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(dout_en === 1'b0, "R8", "after reset", {17'd0, dout_en}, 18'd0);
  endtask

  task automatic t_fill;
    for (int i = 0; i < 256; i++) cycle(K_WR, 8'(i), 18'(i * 1031 + 7), 2'b00, "R11");
    flush("R11");
  endtask

  task automatic t_single;
    cycle(K_RD, 8'h05, '0, 2'b11, "R2");
    flush("R2");
    cycle(K_WR, 8'h07, 18'h2A5A5, 2'b00, "R3");
    flush("R3");
    cycle(K_RD, 8'h07, '0, 2'b11, "R3");
    flush("R3");
  endtask

  task automatic t_reject;
    cycle(K_DS, 8'h09, 18'h3FFFF, 2'b00, "R1");
    cycle(K_DS, 8'h0A, 18'h3FFFF, 2'b00, "R1");
    cycle(K_DS, 8'h0C, 18'h3FFFF, 2'b00, "R1");
    cycle(K_DS, 8'h0F, 18'h3FFFF, 2'b00, "R1");
    cycle(K_RD, 8'h09, '0, 2'b11, "R1");
    cycle(K_RD, 8'h0A, '0, 2'b11, "R1");
    cycle(K_RD, 8'h0C, '0, 2'b11, "R1");
    cycle(K_RD, 8'h0F, '0, 2'b11, "R1");
    flush("R1");
  endtask

  task automatic t_bytes;
    cycle(K_WR, 8'h20, 18'h3FFFF, 2'b10, "R4");
    cycle(K_WR, 8'h21, 18'h3FFFF, 2'b01, "R4");
    cycle(K_WR, 8'h22, 18'h3FFFF, 2'b11, "R4");
    flush("R4");
    cycle(K_RD, 8'h20, '0, 2'b11, "R4");
    cycle(K_RD, 8'h21, '0, 2'b11, "R4");
    cycle(K_RD, 8'h22, '0, 2'b11, "R4");
    flush("R4");
  endtask

  task automatic t_b2b;
    cycle(K_WR, 8'h30, 18'h11111, 2'b00, "R11");
    cycle(K_RD, 8'h30, '0, 2'b11, "R9");
    cycle(K_WR, 8'h31, 18'h22222, 2'b00, "R11");
    cycle(K_RD, 8'h30, '0, 2'b11, "R11");
    cycle(K_RD, 8'h31, '0, 2'b11, "R11");
    cycle(K_WR, 8'h30, 18'h3CCCC, 2'b01, "R11");
    cycle(K_RD, 8'h30, '0, 2'b11, "R9");
    cycle(K_WR, 8'h32, 18'h05555, 2'b10, "R11");
    cycle(K_RD, 8'h32, '0, 2'b11, "R9");
    flush("R11");
  endtask

  task automatic t_burst(input logic il, input logic [7:0] start, input string rq);
    mode_il = il;
    flush(rq);
    cycle(K_WR, start, 18'h10001, 2'b00, rq);
    cycle(K_ADV, 8'h00, 18'h20002, 2'b00, rq);
    cycle(K_ADV, 8'h00, 18'h30003, 2'b10, rq);
    cycle(K_ADV, 8'h00, 18'h04004, 2'b01, rq);
    flush(rq);
    cycle(K_RD, start, '0, 2'b11, rq);
    cycle(K_ADV, 8'h00, '0, 2'b11, rq);
    cycle(K_ADV, 8'h00, '0, 2'b11, rq);
    cycle(K_ADV, 8'h00, '0, 2'b11, rq);
    cycle(K_ADV, 8'h00, '0, 2'b11, "R6");  // fifth beat wraps to the start
    flush(rq);
  endtask

  task automatic t_adv_idle;
    flush("R8");
    cycle(K_ADV, 8'h00, 18'h3FFFF, 2'b00, "R8");
    cycle(K_ADV, 8'h00, 18'h3FFFF, 2'b00, "R8");
    flush("R8");
  endtask

  task automatic t_freeze;
    cycle(K_WR, 8'h60, 18'h1E1E1, 2'b00, "R5");
    freeze(3);
    cycle(K_RD, 8'h60, '0, 2'b11, "R5");
    freeze(2);
    cycle(K_DS, 8'h00, '0, 2'b11, "R5");
    freeze(1);
    flush("R5");
  endtask

  task automatic t_oe;
    cycle(K_RD, 8'h05, '0, 2'b11, "R10");
    cycle(K_DS, 8'h00, '0, 2'b11, "R10");
    oe_n = 1'b1;
    #1;
    chk(dout_en === 1'b0, "R10", "oe_n high", {17'd0, dout_en}, 18'd0);
    oe_n = 1'b0;
    #1;
    chk(dout_en === 1'b1, "R10", "oe_n low", {17'd0, dout_en}, 18'd1);
    flush("R10");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_fill();
    t_single();
    t_reject();
    t_bytes();
    t_b2b();
    t_burst(1'b0, 8'h42, "R7");
    t_burst(1'b1, 8'h55, "R7");
    t_adv_idle();
    t_freeze();
    t_oe();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule